// File: doc/BRIEF.md
# Timer Timebase with Trigger Output

This block is the counting core of a general-purpose timer. A prescaler divides the system clock. Its output steps an up/down counter that runs between zero and an auto-reload limit. Each time the counter wraps, the block raises a one-cycle update event. The block also drives a trigger output that other timers can use as a synchronisation source. An encoded mode field selects what appears on that output: the update strobe alone, the enable level, every update event, a compare pulse, or one of four externally supplied compare reference levels.

Configuration arrives on a single-cycle write port. A 3-bit select code picks the target. Code 0 writes the prescaler. Code 1 writes the auto-reload value. Code 2 writes the count. Code 3 writes the control word: bit 0 enables counting, bit 1 selects down counting, bit 2 enables auto-reload preload, and bits 6:4 hold the trigger mode. Code 4 is a software update strobe, and its data is ignored. Code 5 writes the compare value used by trigger mode 3. Written values become visible on the outputs in the cycle after the write. Prescaler writes and preloaded auto-reload writes wait in shadow registers until the next update event.

Top module: `tmr_timebase`

## Requirements
- R1: After reset, cnt_out, upd_evt and trig_out are 0, counting is disabled, and the count does not move.
- R2: While enabled, update events repeat every (prescaler+1)*(auto-reload+1) clock cycles.
- R3: Counting up, the counter wraps from the auto-reload value to 0. Counting down (control bit 1 = 1), it wraps from 0 to the auto-reload value. upd_evt is high for exactly the cycle in which the wrapped value first appears on cnt_out.
- R4: With preload on (control bit 2 = 1), an auto-reload write takes effect only at the next update event. With preload off, it takes effect on the next cycle.
- R5: A prescaler write takes effect only at the next update event.
- R6: A write with select code 4 ignores its data and, on the next cycle, raises upd_evt. It also loads both shadow registers, clears the prescaler phase, and sets the count to 0 (up) or to the auto-reload value (down).
- R7: With control bit 0 clear, the count holds. Prescaler and auto-reload can be written, including to zero, and the count stays where it was.
- R8: A write with select code 2 sets cnt_out to the written value on the next cycle.
- R9: In trigger mode 0, trig_out pulses for one cycle only after a software update strobe, and not on counter wraps.
- R10: In trigger mode 1, trig_out follows the counter enable level.
- R11: In trigger mode 2, trig_out equals upd_evt.
- R12: In trigger mode 3, trig_out is high for one cycle when the counter takes a new value equal to the compare value (select code 5).
- R13: In trigger modes 4 to 7, trig_out is oc_ref[mode-4], registered one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 3 | Write target: 0 prescaler, 1 auto-reload, 2 count, 3 control, 4 update strobe, 5 compare |
| wr_data | input | 16 | Write data |
| oc_ref | input | 4 | Compare reference levels routed by trigger modes 4 to 7 |
| cnt_out | output | 16 | Current count |
| upd_evt | output | 1 | One-cycle update event |
| trig_out | output | 1 | Selected trigger output |

## Verification
The assertions check these rules on every cycle:
- In mode 1, the trigger output matches the enable level.
- In mode 2, the trigger output matches the update event.
- A stopped, unwritten counter holds its value.
- An update strobe is followed by an update event.
- The active auto-reload value equals its shadow after every update.
- A compare pulse never lasts two cycles.

Other behaviours need the bench's scenarios:
- Event periods for several prescaler, limit and direction combinations.
- The value the counter shows when it wraps.
- Deferred versus immediate auto-reload writes.
- Deferred prescaler changes.
- The routing of each compare reference input.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    SEL_PSC  = 3'd0,
    SEL_ARR  = 3'd1,
    SEL_CNT  = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_UG   = 3'd4,
    SEL_CMP  = 3'd5
  } wsel_e;

  typedef enum logic [2:0] {
    MM_RESET  = 3'd0,
    MM_ENABLE = 3'd1,
    MM_UPDATE = 3'd2,
    MM_CMP    = 3'd3,
    MM_OC1    = 3'd4,
    MM_OC2    = 3'd5,
    MM_OC3    = 3'd6,
    MM_OC4    = 3'd7
  } mmode_e;

  localparam int CTL_EN   = 0;
  localparam int CTL_DIR  = 1;
  localparam int CTL_ARPE = 2;
  localparam int CTL_MMLO = 4;
  localparam int CTL_MMHI = 6;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             reload,
  input  logic             clear,
  input  logic             psc_we,
  input  logic [PSC_W-1:0] psc_wd,
  output logic             tick
);
  logic [PSC_W-1:0] psc_buf, psc_act, phase;

  assign tick = run && (phase == psc_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_buf <= '0;
      psc_act <= '0;
      phase   <= '0;
    end else begin
      if (psc_we) psc_buf <= psc_wd;
      if (reload) psc_act <= psc_we ? psc_wd : psc_buf;
      if (clear || tick) phase <= '0;
      else if (run) phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             down,
  input  logic             ug,
  input  logic             cnt_we,
  input  logic             arr_we,
  input  logic             preload,
  input  logic [CNT_W-1:0] wd,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nx,
  output logic [CNT_W-1:0] arr_act,
  output logic [CNT_W-1:0] arr_buf,
  output logic             upd_nx
);
  logic [CNT_W-1:0] arr_src;
  logic             wrap;

  assign arr_src = arr_we ? wd : arr_buf;
  assign wrap    = tick && (down ? (cnt_q == '0) : (cnt_q == arr_act));
  assign upd_nx  = wrap || ug;

  always_comb begin
    if (cnt_we)          cnt_nx = wd;
    else if (ug || wrap) cnt_nx = down ? arr_src : '0;
    else if (tick)       cnt_nx = down ? cnt_q - 1'b1 : cnt_q + 1'b1;
    else                 cnt_nx = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      arr_buf <= '0;
      arr_act <= '0;
    end else begin
      cnt_q <= cnt_nx;
      if (arr_we) arr_buf <= wd;
      if (arr_we && !preload) arr_act <= wd;
      else if (upd_nx)        arr_act <= arr_src;
    end
  end
endmodule

// File: rtl/tmr_trgo_mux.sv
module tmr_trgo_mux
  import tmr_pkg::*;
#(
  parameter int N_OC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      mode,
  input  logic            ug,
  input  logic            en_nx,
  input  logic            upd_nx,
  input  logic            cmp_nx,
  input  logic [N_OC-1:0] oc_ref,
  output logic            trig
);
  localparam int OC_IW = (N_OC > 1) ? $clog2(N_OC) : 1;
  logic [OC_IW-1:0] oc_idx;
  logic             sel_nx;

  assign oc_idx = OC_IW'(mode - 3'd4);

  always_comb begin
    case (mmode_e'(mode))
      MM_RESET:  sel_nx = ug;
      MM_ENABLE: sel_nx = en_nx;
      MM_UPDATE: sel_nx = upd_nx;
      MM_CMP:    sel_nx = cmp_nx;
      default:   sel_nx = oc_ref[oc_idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) trig <= 1'b0;
    else     trig <= sel_nx;
  end
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int N_OC  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [N_OC-1:0]  oc_ref,
  output logic [CNT_W-1:0] cnt_out,
  output logic             upd_evt,
  output logic             trig_out
);
  logic             we_psc, we_arr, we_cnt, we_ctl, we_ug, we_cmp;
  logic             en_q, dir_q, arpe_q, en_nx, dir_nx, arpe_nx;
  logic [2:0]       mms_q, mms_nx;
  logic [CNT_W-1:0] ccr_q, cnt_nx, arr_act, arr_buf;
  logic             tick, upd_nx, cmp_nx;

  assign we_psc = wr_en && (wr_sel == SEL_PSC);
  assign we_arr = wr_en && (wr_sel == SEL_ARR);
  assign we_cnt = wr_en && (wr_sel == SEL_CNT);
  assign we_ctl = wr_en && (wr_sel == SEL_CTRL);
  assign we_ug  = wr_en && (wr_sel == SEL_UG);
  assign we_cmp = wr_en && (wr_sel == SEL_CMP);

  assign en_nx   = we_ctl ? wr_data[CTL_EN]   : en_q;
  assign dir_nx  = we_ctl ? wr_data[CTL_DIR]  : dir_q;
  assign arpe_nx = we_ctl ? wr_data[CTL_ARPE] : arpe_q;
  assign mms_nx  = we_ctl ? wr_data[CTL_MMHI:CTL_MMLO] : mms_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      dir_q   <= 1'b0;
      arpe_q  <= 1'b0;
      mms_q   <= MM_RESET;
      ccr_q   <= '0;
      upd_evt <= 1'b0;
    end else begin
      en_q    <= en_nx;
      dir_q   <= dir_nx;
      arpe_q  <= arpe_nx;
      mms_q   <= mms_nx;
      if (we_cmp) ccr_q <= wr_data;
      upd_evt <= upd_nx;
    end
  end

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .run(en_q), .reload(upd_nx), .clear(we_ug),
    .psc_we(we_psc), .psc_wd(wr_data[PSC_W-1:0]), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .down(dir_q), .ug(we_ug),
    .cnt_we(we_cnt), .arr_we(we_arr), .preload(arpe_q), .wd(wr_data),
    .cnt_q(cnt_out), .cnt_nx(cnt_nx), .arr_act(arr_act), .arr_buf(arr_buf),
    .upd_nx(upd_nx)
  );

  assign cmp_nx = (cnt_nx != cnt_out) && (cnt_nx == ccr_q);

  tmr_trgo_mux #(.N_OC(N_OC)) u_mux (
    .clk(clk), .rst(rst), .mode(mms_nx), .ug(we_ug), .en_nx(en_nx),
    .upd_nx(upd_nx), .cmp_nx(cmp_nx), .oc_ref(oc_ref), .trig(trig_out)
  );
endmodule

// File: rtl/tmr_timebase_chk.sv
module tmr_timebase_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       wr_sel,
  input logic [CNT_W-1:0] cnt_out,
  input logic             upd_evt,
  input logic             trig_out,
  input logic             en_q,
  input logic [2:0]       mms_q,
  input logic [CNT_W-1:0] ccr_q,
  input logic [CNT_W-1:0] arr_act,
  input logic [CNT_W-1:0] arr_buf
);
  assert_enable_follow_R10: assert property (@(posedge clk) disable iff (rst)
    (mms_q == MM_ENABLE) |-> (trig_out == en_q));

  assert_update_route_R11: assert property (@(posedge clk) disable iff (rst)
    (mms_q == MM_UPDATE) |-> (trig_out == upd_evt));

  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !wr_en) |=> $stable(cnt_out));

  assert_strobe_update_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_UG) |=> upd_evt);

  assert_shadow_loaded_R4: assert property (@(posedge clk) disable iff (rst)
    upd_evt |-> (arr_act == arr_buf));

  assert_cmp_single_R12: assert property (@(posedge clk) disable iff (rst)
    (mms_q == MM_CMP && trig_out && !wr_en && cnt_out == ccr_q)
      |=> !(trig_out && mms_q == MM_CMP));
endmodule

bind tmr_timebase tmr_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .cnt_out(cnt_out),
  .upd_evt(upd_evt), .trig_out(trig_out), .en_q(en_q), .mms_q(mms_q),
  .ccr_q(ccr_q), .arr_act(arr_act), .arr_buf(arr_buf)
);

// File: tb/sim_tmr_timebase.sv
`timescale 1ns/1ps
module sim_tmr_timebase;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic [3:0]  oc_ref = 4'd0;
  logic [15:0] cnt_out;
  logic        upd_evt, trig_out;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tmr_timebase u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .oc_ref(oc_ref), .cnt_out(cnt_out), .upd_evt(upd_evt), .trig_out(trig_out)
  );

  // {prescaler, auto-reload, down, expected period}
  localparam logic [31:0] VEC [6] = '{
    {8'd0, 8'd3, 8'd0, 8'd4},
    {8'd1, 8'd4, 8'd0, 8'd10},
    {8'd2, 8'd2, 8'd1, 8'd9},
    {8'd0, 8'd0, 8'd0, 8'd1},
    {8'd3, 8'd1, 8'd1, 8'd8},
    {8'd0, 8'd6, 8'd1, 8'd7}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    wr_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] ctl(input bit en, input bit dn, input bit pre, input int m);
    return {9'd0, 3'(m), 1'b0, pre, dn, en};
  endfunction

  task automatic wait_upd(output int c);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!upd_evt && c < 2000);
  endtask

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c, ups, trigs, bad;
    logic [15:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk(cnt_out == 0 && !upd_evt && !trig_out, "R1 reset outputs", cnt_out, 0);
    repeat (4) @(negedge clk);
    chk(cnt_out == 0, "R1 idle after reset", cnt_out, 0);

    // Table walk: period and wrap value per configuration
    for (int i = 0; i < 6; i++) begin
      logic [7:0] p, a, dn, per;
      {p, a, dn, per} = VEC[i];
      wr(3'd3, ctl(0, dn[0], 0, 2));
      wr(3'd0, 16'(p));
      wr(3'd1, 16'(a));
      wr(3'd4, 16'd0);
      chk(cnt_out == (dn[0] ? a : 0), "R6 strobe initial count", cnt_out, dn[0] ? a : 0);
      wr(3'd3, ctl(1, dn[0], 0, 2));
      wait_upd(c);
      chk(cnt_out == (dn[0] ? a : 0), "R3 wrapped value", cnt_out, dn[0] ? a : 0);
      wait_upd(c);
      chk(c == int'(per), "R2 update period", c, per);
      chk(trig_out == 1'b1, "R11 trigger on update", trig_out, 1);
    end

    // R4 preload on: deferred auto-reload
    wr(3'd3, ctl(0, 0, 0, 2));
    wr(3'd0, 16'd0);
    wr(3'd4, 16'd0);
    wr(3'd1, 16'd9);
    wr(3'd3, ctl(0, 0, 1, 2));
    wr(3'd1, 16'd2);
    wr(3'd2, 16'd0);
    wr(3'd3, ctl(1, 0, 1, 2));
    wait_upd(c);
    chk(c == 10, "R4 preload defers limit", c, 10);
    wait_upd(c);
    chk(c == 3, "R4 preload applied at update", c, 3);

    // R4 preload off: immediate auto-reload
    wr(3'd3, ctl(0, 0, 0, 2));
    wr(3'd1, 16'd9);
    wr(3'd2, 16'd0);
    wr(3'd3, ctl(1, 0, 0, 2));
    @(negedge clk); @(negedge clk);
    wr(3'd1, 16'd3);
    wait_upd(c);
    chk(c == 1, "R4 immediate limit", c, 1);
    wait_upd(c);
    chk(c == 4, "R4 immediate period", c, 4);

    // R5 prescaler deferred
    wr(3'd0, 16'd1);
    wait_upd(c);
    chk(c == 3, "R5 prescaler not yet active", c, 3);
    wait_upd(c);
    chk(c == 8, "R5 prescaler after update", c, 8);

    // R6 strobe mid-count, data ignored
    wr(3'd3, ctl(1, 1, 0, 2));
    repeat (3) @(negedge clk);
    wr(3'd4, 16'hFFFF);
    chk(upd_evt && cnt_out == 3, "R6 down strobe reload", cnt_out, 3);
    wr(3'd3, ctl(1, 0, 0, 2));
    wr(3'd4, 16'h00A5);
    chk(upd_evt && cnt_out == 0, "R6 up strobe clear", cnt_out, 0);
    wait_upd(c);
    chk(c == 8, "R6 prescaler phase cleared", c, 8);

    // R7 disabled holds, zero writes allowed
    wr(3'd3, ctl(0, 0, 0, 2));
    held = cnt_out;
    wr(3'd0, 16'd0);
    wr(3'd1, 16'd0);
    repeat (5) @(negedge clk);
    chk(cnt_out == held && !upd_evt, "R7 count holds when off", cnt_out, held);

    // R8 count write
    wr(3'd2, 16'h1234);
    chk(cnt_out == 16'h1234, "R8 count write", cnt_out, 16'h1234);

    // R10 enable level
    wr(3'd3, ctl(1, 0, 0, 1));
    repeat (3) @(negedge clk);
    chk(trig_out == 1'b1, "R10 trigger follows enable high", trig_out, 1);
    wr(3'd3, ctl(0, 0, 0, 1));
    chk(trig_out == 1'b0, "R10 trigger follows enable low", trig_out, 0);

    // R9 mode 0: strobe only
    wr(3'd1, 16'd2);
    wr(3'd3, ctl(0, 0, 0, 0));
    wr(3'd4, 16'd0);
    chk(trig_out == 1'b1, "R9 strobe pulse", trig_out, 1);
    @(negedge clk);
    chk(trig_out == 1'b0, "R9 pulse single cycle", trig_out, 0);
    wr(3'd3, ctl(1, 0, 0, 0));
    ups = 0; trigs = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      ups += upd_evt; trigs += trig_out;
    end
    chk(ups >= 3 && trigs == 0, "R9 no trigger on wraps", trigs, 0);

    // R11 window
    wr(3'd3, ctl(1, 0, 0, 2));
    bad = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (trig_out != upd_evt) bad++;
    end
    chk(bad == 0, "R11 trigger equals update", bad, 0);

    // R12 compare pulse
    wr(3'd3, ctl(0, 0, 0, 3));
    wr(3'd1, 16'd4);
    wr(3'd5, 16'd2);
    wr(3'd4, 16'd0);
    wr(3'd3, ctl(1, 0, 0, 3));
    trigs = 0; bad = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      trigs += trig_out;
      if (trig_out != (cnt_out == 16'd2)) bad++;
    end
    chk(trigs == 2 && bad == 0, "R12 compare pulses", trigs, 2);

    // R13 reference routing
    wr(3'd3, ctl(0, 0, 0, 2));
    for (int m = 4; m < 8; m++) begin
      oc_ref = 4'(1 << (m - 4));
      wr(3'd3, ctl(0, 0, 0, m));
      chk(trig_out == 1'b1, "R13 reference high", trig_out, 1);
      oc_ref = ~(4'(1 << (m - 4)));
      @(negedge clk);
      chk(trig_out == 1'b0, "R13 reference low", trig_out, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule